// File: doc/BRIEF.md
# OUT Packet Receive-Buffer Allocator

This block hands out receive buffers for a USB full-speed device whose packet memory is split into 32 buffers of 64 bytes. Software loads free buffer IDs into a small free-ID queue. When the protocol engine reports a token for an OUT or SETUP packet, the allocator decides whether it can take the packet. The endpoint must have reception of that transaction type enabled, a free ID must be waiting, and the completion queue must have room. If the packet is taken, the allocator presents the buffer ID at the head of the free queue to the packet writer.

When the packet ends, the allocator picks the handshake. On a good CRC for a taken packet it sends ACK. It then consumes the free ID and queues a completion descriptor for software: buffer ID, payload length, endpoint and a SETUP flag. A refused OUT gets a NAK. A refused SETUP, or any packet with a bad CRC, gets no handshake. A bad-CRC packet leaves its free ID at the head of the queue.

Each endpoint has an auto-NAK option. When it is set, accepting one OUT packet turns off that endpoint's OUT reception, so later OUTs are NAKed until software turns it back on.

Top module: `rxBufAlloc`

## Requirements
- R1: The free-ID queue holds 4 entries and hands IDs out in the order they were pushed. A push while it holds 4 entries is ignored.
- R2: When a token is taken, `wrBufValid` is high from the cycle after `pktStart` until the cycle after `pktEnd`. During that time `wrBufId` equals the head of the free-ID queue.
- R3: A taken packet that ends with a good CRC gets `hsCode` 1 (ACK). It consumes the free ID and queues a descriptor with that ID, the endpoint, the SETUP flag, and a length equal to `pktBytes` minus 2 (the CRC bytes). The length is 0 when `pktBytes` is below 2.
- R4: An OUT to an endpoint whose `outEnable` bit is clear, or whose number is 12 or above, gets `hsCode` 2 (NAK). It queues nothing and leaves the free-ID queue untouched.
- R5: A SETUP to an endpoint whose `setupEnable` bit is clear gets `hsCode` 0 (no handshake) and queues nothing.
- R6: If the free-ID queue is empty or the completion queue (4 entries) is full when the token arrives, an OUT gets NAK (2) and a SETUP gets no handshake (0).
- R7: A bad CRC (`pktCrcOk` low at `pktEnd`) gives `hsCode` 0. Nothing is queued, and the same free ID is offered to the next packet.
- R8: When an OUT packet is ACKed on an endpoint whose `autoNakEnable` bit is set, that endpoint's `outEnable` bit clears. A SETUP leaves `outEnable` unchanged. A software write (`outEnWrite`) in the same cycle takes priority.
- R9: `rxValid`, the packet-received interrupt, is high exactly while the completion queue is not empty. The `rx*` outputs show the oldest descriptor, and `rxPop` removes it.
- R10: `hsValid` pulses for one cycle, in the cycle after the `pktEnd` that closes a token. A `pktStart` during an open token and a `pktEnd` with no open token are ignored.
- R11: After reset, `outEnable` is 0, both queues are empty, and `hsValid`, `wrBufValid` and `rxValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freeIdValid | input | 1 | Push `freeId` into the free-ID queue |
| freeId | input | 5 | Free buffer ID from software |
| outEnWrite | input | 1 | Load `outEnData` into the OUT-enable vector |
| outEnData | input | 12 | New OUT-enable vector |
| setupEnable | input | 12 | Per-endpoint SETUP reception enable |
| autoNakEnable | input | 12 | Per-endpoint auto-NAK after one accepted OUT |
| pktStart | input | 1 | Token for a host-to-device packet |
| pktSetup | input | 1 | Token is SETUP (1) or OUT (0) |
| pktEp | input | 4 | Endpoint number of the token |
| pktEnd | input | 1 | Data packet finished |
| pktCrcOk | input | 1 | Data packet CRC was good |
| pktBytes | input | 7 | Received bytes including the two CRC bytes |
| rxPop | input | 1 | Remove the oldest completion descriptor |
| wrBufValid | output | 1 | A buffer is assigned to the current packet |
| wrBufId | output | 5 | Assigned buffer ID for the packet writer |
| hsValid | output | 1 | Handshake decision strobe |
| hsCode | output | 2 | 0 none, 1 ACK, 2 NAK |
| outEnable | output | 12 | Current OUT reception enables |
| rxValid | output | 1 | Completion queue not empty (interrupt) |
| rxBufId | output | 5 | Oldest descriptor: buffer ID |
| rxLen | output | 7 | Oldest descriptor: payload length in bytes |
| rxEp | output | 4 | Oldest descriptor: endpoint |
| rxSetup | output | 1 | Oldest descriptor: SETUP flag |

## Verification
The bench fills both queues to their limits. It then sends OUT and SETUP tokens so the difference between a NAK and a silent drop shows up. A design that swapped these, or accepted while full, would show the wrong `hsCode`, or a descriptor would disappear or be repeated. A bad-CRC packet is followed by a good one; a design that consumed the ID early would hand out the next ID instead of the same one. Auto-NAK is exercised on both OUT and SETUP, so a design that cleared the bit on SETUP, or never cleared it, would show a wrong `outEnable` and an ACK where a NAK is due. Zero-length and maximum-length packets test the CRC byte subtraction.

// File: rtl/rxAllocPkg.sv
package rxAllocPkg;
  parameter int NumBufs  = 32;
  parameter int BufBytes = 64;
  parameter int NumEp    = 12;

  localparam int BufIdW = $clog2(NumBufs);
  localparam int LenW   = $clog2(BufBytes + 1);
  localparam int EpW    = $clog2(NumEp);
  localparam int CntW   = $clog2(BufBytes + 3);

  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NAK  = 2'd2
  } hsCode_e;

  typedef struct packed {
    logic availPop;
    logic rxPush;
  } allocStrobes_t;

  typedef struct packed {
    logic [BufIdW-1:0] bufId;
    logic [LenW-1:0]   len;
    logic [EpW-1:0]    ep;
    logic              setup;
  } rxDesc_t;
endpackage

// File: rtl/syncFifo.sv
module syncFifo #(
  parameter int Width = 8,
  parameter int Depth = 4,
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1,
  localparam int CntW = $clog2(Depth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [Width-1:0] pushData,
  input  logic             pop,
  output logic [Width-1:0] headData,
  output logic [CntW-1:0]  count
);
  logic [Width-1:0] mem [Depth];
  logic [PtrW-1:0]  rdPtr, wrPtr;
  logic             isFull, isEmpty, doPush, doPop;

  assign isFull   = (count == CntW'(Depth));
  assign isEmpty  = (count == '0);
  assign doPush   = push && !isFull;
  assign doPop    = pop && !isEmpty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == PtrW'(Depth - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == PtrW'(Depth - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntW'(Depth));
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && isFull) |=> (count == CntW'(Depth)));
endmodule

// File: rtl/rxAllocCtrl.sv
module rxAllocCtrl import rxAllocPkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pktStart,
  input  logic                pktSetup,
  input  logic [EpW-1:0]      pktEp,
  input  logic                pktEnd,
  input  logic                pktCrcOk,
  input  logic [CntW-1:0]     pktBytes,
  input  logic                outEnWrite,
  input  logic [NumEp-1:0]    outEnData,
  input  logic [NumEp-1:0]    setupEnable,
  input  logic [NumEp-1:0]    autoNakEnable,
  input  logic                availEmpty,
  input  logic                rxFull,
  output allocStrobes_t       strobes,
  output logic [LenW-1:0]     descLen,
  output logic [EpW-1:0]      descEp,
  output logic                descSetup,
  output logic                wrBufValid,
  output logic                hsValid,
  output logic [1:0]          hsCode,
  output logic [NumEp-1:0]    outEnable
);
  logic             active, actSetup, actAccept, hsValidQ;
  logic [EpW-1:0]   actEp;
  hsCode_e          hsReg, verdict;
  logic [NumEp-1:0] outEnQ, startMask, actMask;
  logic             epEnabled, takeStart, finish, ackNow;

  assign startMask = NumEp'(1) << pktEp;
  assign actMask   = NumEp'(1) << actEp;
  assign epEnabled = pktSetup ? |(setupEnable & startMask) : |(outEnQ & startMask);
  assign takeStart = pktStart && !active;
  assign finish    = pktEnd && active;
  assign ackNow    = finish && pktCrcOk && actAccept;

  always_comb begin
    if (!pktCrcOk)     verdict = HS_NONE;
    else if (actAccept) verdict = HS_ACK;
    else if (actSetup)  verdict = HS_NONE;
    else                verdict = HS_NAK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      actSetup  <= 1'b0;
      actAccept <= 1'b0;
      actEp     <= '0;
      hsValidQ  <= 1'b0;
      hsReg     <= HS_NONE;
      outEnQ    <= '0;
    end else begin
      hsValidQ <= finish;
      if (finish) begin
        hsReg  <= verdict;
        active <= 1'b0;
      end else if (takeStart) begin
        active    <= 1'b1;
        actSetup  <= pktSetup;
        actEp     <= pktEp;
        actAccept <= epEnabled && !availEmpty && !rxFull;
      end
      if (outEnWrite)                outEnQ <= outEnData;
      else if (ackNow && !actSetup)  outEnQ <= outEnQ & ~(actMask & autoNakEnable);
    end
  end

  assign strobes.availPop = ackNow;
  assign strobes.rxPush   = ackNow;
  assign descLen   = (pktBytes >= CntW'(2)) ? LenW'(pktBytes - CntW'(2)) : '0;
  assign descEp    = actEp;
  assign descSetup = actSetup;
  assign wrBufValid = active && actAccept;
  assign hsValid   = hsValidQ;
  assign hsCode    = hsReg;
  assign outEnable = outEnQ;

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.availPop |-> !availEmpty);
  p_hs_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |=> !hsValid);
  p_autonak_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxPush && !descSetup && |(autoNakEnable & actMask) && !outEnWrite)
      |=> ((outEnable & $past(actMask)) == '0));
endmodule

// File: rtl/rxAllocData.sv
module rxAllocData import rxAllocPkg::*; #(
  parameter int AvailDepth = 4,
  parameter int RxDepth    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              freeIdValid,
  input  logic [BufIdW-1:0] freeId,
  input  logic              rxPop,
  input  allocStrobes_t     strobes,
  input  logic [LenW-1:0]   descLen,
  input  logic [EpW-1:0]    descEp,
  input  logic              descSetup,
  output logic              availEmpty,
  output logic              rxFull,
  output logic [BufIdW-1:0] availHead,
  output logic              rxValid,
  output rxDesc_t           rxHead
);
  localparam int AvCntW = $clog2(AvailDepth + 1);
  localparam int RxCntW = $clog2(RxDepth + 1);
  localparam int DescW  = $bits(rxDesc_t);

  logic [AvCntW-1:0] availCount;
  logic [RxCntW-1:0] rxCount;
  rxDesc_t           newDesc;
  logic [DescW-1:0]  rxHeadBits;

  assign newDesc = '{bufId: availHead, len: descLen, ep: descEp, setup: descSetup};

  syncFifo #(.Width(BufIdW), .Depth(AvailDepth)) u_availFifo (
    .clk(clk), .rstN(rstN),
    .push(freeIdValid), .pushData(freeId),
    .pop(strobes.availPop), .headData(availHead), .count(availCount));

  syncFifo #(.Width(DescW), .Depth(RxDepth)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.rxPush), .pushData(newDesc),
    .pop(rxPop), .headData(rxHeadBits), .count(rxCount));

  assign rxHead     = rxDesc_t'(rxHeadBits);
  assign availEmpty = (availCount == '0);
  assign rxFull     = (rxCount == RxCntW'(RxDepth));
  assign rxValid    = (rxCount != '0);
endmodule

// File: rtl/rxBufAlloc.sv
module rxBufAlloc import rxAllocPkg::*; #(
  parameter int AvailDepth = 4,
  parameter int RxDepth    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              freeIdValid,
  input  logic [BufIdW-1:0] freeId,
  input  logic              outEnWrite,
  input  logic [NumEp-1:0]  outEnData,
  input  logic [NumEp-1:0]  setupEnable,
  input  logic [NumEp-1:0]  autoNakEnable,
  input  logic              pktStart,
  input  logic              pktSetup,
  input  logic [EpW-1:0]    pktEp,
  input  logic              pktEnd,
  input  logic              pktCrcOk,
  input  logic [CntW-1:0]   pktBytes,
  input  logic              rxPop,
  output logic              wrBufValid,
  output logic [BufIdW-1:0] wrBufId,
  output logic              hsValid,
  output logic [1:0]        hsCode,
  output logic [NumEp-1:0]  outEnable,
  output logic              rxValid,
  output logic [BufIdW-1:0] rxBufId,
  output logic [LenW-1:0]   rxLen,
  output logic [EpW-1:0]    rxEp,
  output logic              rxSetup
);
  allocStrobes_t     strobes;
  logic [LenW-1:0]   descLen;
  logic [EpW-1:0]    descEp;
  logic              descSetup, availEmpty, rxFull;
  logic [BufIdW-1:0] availHead;
  rxDesc_t           rxHead;

  rxAllocCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .pktStart(pktStart), .pktSetup(pktSetup), .pktEp(pktEp),
    .pktEnd(pktEnd), .pktCrcOk(pktCrcOk), .pktBytes(pktBytes),
    .outEnWrite(outEnWrite), .outEnData(outEnData),
    .setupEnable(setupEnable), .autoNakEnable(autoNakEnable),
    .availEmpty(availEmpty), .rxFull(rxFull),
    .strobes(strobes), .descLen(descLen), .descEp(descEp), .descSetup(descSetup),
    .wrBufValid(wrBufValid), .hsValid(hsValid), .hsCode(hsCode),
    .outEnable(outEnable));

  rxAllocData #(.AvailDepth(AvailDepth), .RxDepth(RxDepth)) u_data (
    .clk(clk), .rstN(rstN),
    .freeIdValid(freeIdValid), .freeId(freeId), .rxPop(rxPop),
    .strobes(strobes), .descLen(descLen), .descEp(descEp), .descSetup(descSetup),
    .availEmpty(availEmpty), .rxFull(rxFull), .availHead(availHead),
    .rxValid(rxValid), .rxHead(rxHead));

  assign wrBufId = availHead;
  assign rxBufId = rxHead.bufId;
  assign rxLen   = rxHead.len;
  assign rxEp    = rxHead.ep;
  assign rxSetup = rxHead.setup;
endmodule

// File: tb/rxBufAlloc_bench.sv
module rxBufAlloc_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freeIdValid = 0; logic [4:0] freeId = 0;
  logic outEnWrite = 0;  logic [11:0] outEnData = 0;
  logic [11:0] setupEnable = 0, autoNakEnable = 0;
  logic pktStart = 0, pktSetup = 0, pktEnd = 0, pktCrcOk = 0, rxPop = 0;
  logic [3:0] pktEp = 0; logic [6:0] pktBytes = 0;
  logic wrBufValid, hsValid, rxValid, rxSetup;
  logic [4:0] wrBufId, rxBufId; logic [1:0] hsCode;
  logic [11:0] outEnable; logic [6:0] rxLen; logic [3:0] rxEp;

  always #2.5 clk = ~clk;

  rxBufAlloc u_rxBufAlloc (.*);

  int checks = 0, errors = 0;

  // behavioural reference
  int availQ[$]; int rxQ[$];
  bit mActive, mSetup, mAccept, mHsValid; int mEp, mHsCode; logic [11:0] mOutEn;

  always @(posedge clk) begin
    if (!rstN) begin
      availQ.delete(); rxQ.delete();
      mActive = 0; mSetup = 0; mAccept = 0; mHsValid = 0; mEp = 0; mHsCode = 0; mOutEn = '0;
    end else begin
      int availPre, rxPre, len; bit ackNow, en;
      availPre = availQ.size(); rxPre = rxQ.size(); ackNow = 0;
      mHsValid = 0;
      if (mActive && pktEnd) begin
        mHsValid = 1;
        if (!pktCrcOk) mHsCode = 0;
        else if (mAccept) mHsCode = 1;
        else if (mSetup) mHsCode = 0;
        else mHsCode = 2;
        ackNow = pktCrcOk && mAccept;
        mActive = 0;
      end else if (!mActive && pktStart) begin
        mActive = 1; mSetup = pktSetup; mEp = int'(pktEp);
        en = (mEp < 12) && (pktSetup ? setupEnable[mEp] : mOutEn[mEp]);
        mAccept = en && availPre > 0 && rxPre < 4;
      end
      if (rxPop && rxPre > 0) void'(rxQ.pop_front());
      if (ackNow) begin
        len = (pktBytes >= 2) ? int'(pktBytes) - 2 : 0;
        rxQ.push_back(availQ.pop_front() | (len << 5) | (mEp << 12) | (int'(mSetup) << 16));
      end
      if (freeIdValid && availPre < 4) availQ.push_back(int'(freeId));
      if (outEnWrite) mOutEn = outEnData;
      else if (ackNow && !mSetup && autoNakEnable[mEp]) mOutEn[mEp] = 1'b0;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit ev; ev = mActive && mAccept;
    cmp("R11/R9 rxValid", int'(rxValid), int'(rxQ.size() > 0));
    if (rxQ.size() > 0) begin
      cmp("R3 rxBufId", int'(rxBufId), rxQ[0] & 31);
      cmp("R3 rxLen", int'(rxLen), (rxQ[0] >> 5) & 127);
      cmp("R3 rxEp", int'(rxEp), (rxQ[0] >> 12) & 15);
      cmp("R3 rxSetup", int'(rxSetup), (rxQ[0] >> 16) & 1);
    end
    cmp("R10 hsValid", int'(hsValid), int'(mHsValid));
    if (mHsValid) cmp("R4/R5/R6/R7 hsCode", int'(hsCode), mHsCode);
    cmp("R2 wrBufValid", int'(wrBufValid), int'(ev));
    if (ev) cmp("R2/R1 wrBufId", int'(wrBufId), availQ[0]);
    cmp("R8 outEnable", int'(outEnable), int'(mOutEn));
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  task automatic pushId(int id);
    step(); freeIdValid = 1; freeId = 5'(id);
    step(); freeIdValid = 0;
  endtask

  task automatic writeOutEn(int v);
    step(); outEnWrite = 1; outEnData = 12'(v);
    step(); outEnWrite = 0;
  endtask

  task automatic sendPkt(bit s, int ep, bit crc, int bytes, output int hs, output int wr);
    step(); pktStart = 1; pktSetup = s; pktEp = 4'(ep);
    step(); pktStart = 0;
    wr = wrBufValid ? int'(wrBufId) : -1;
    step(); pktEnd = 1; pktCrcOk = crc; pktBytes = 7'(bytes);
    step(); pktEnd = 0;
    hs = hsValid ? int'(hsCode) : -1;
  endtask

  task automatic popCheck(int id, int len, int ep, int s);
    step();
    cmp("R9 rxValid before pop", int'(rxValid), 1);
    cmp("R3 popped id", int'(rxBufId), id);
    cmp("R3 popped len", int'(rxLen), len);
    cmp("R3 popped ep", int'(rxEp), ep);
    cmp("R3 popped setup", int'(rxSetup), s);
    rxPop = 1;
    step(); rxPop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hs, wr;
    repeat (3) step();
    cmp("R11 reset rxValid", int'(rxValid), 0);
    cmp("R11 reset outEnable", int'(outEnable), 0);
    cmp("R11 reset hsValid", int'(hsValid), 0);
    cmp("R11 reset wrBufValid", int'(wrBufValid), 0);
    rstN = 1;
    setupEnable = 12'hEFF;
    writeOutEn(12'hFFF);
    pushId(5); pushId(9); pushId(17); pushId(30); pushId(2); // R1: last one dropped
    sendPkt(0, 1, 1, 10, hs, wr);
    cmp("R2 first buffer", wr, 5); cmp("R3 ack", hs, 1);
    sendPkt(0, 2, 0, 20, hs, wr);
    cmp("R7 bad crc hs", hs, 0); cmp("R2 second buffer", wr, 9);
    sendPkt(0, 2, 1, 2, hs, wr);
    cmp("R7 same id reused", wr, 9); cmp("R3 zero-length ack", hs, 1);
    sendPkt(1, 0, 1, 10, hs, wr);
    cmp("R1 third id", wr, 17); cmp("R3 setup ack", hs, 1);
    sendPkt(0, 3, 1, 66, hs, wr);
    cmp("R1 fourth id", wr, 30); cmp("R3 max ack", hs, 1);
    sendPkt(0, 1, 1, 10, hs, wr);
    cmp("R6 empty out nak", hs, 2); cmp("R6 no buffer", wr, -1);
    sendPkt(1, 0, 1, 10, hs, wr);
    cmp("R6 empty setup silent", hs, 0);
    pushId(7);
    sendPkt(0, 1, 1, 10, hs, wr);
    cmp("R6 rx full out nak", hs, 2);
    popCheck(5, 8, 1, 0); popCheck(9, 0, 2, 0);
    popCheck(17, 8, 0, 1); popCheck(30, 64, 3, 0);
    step(); cmp("R9 rxValid low when drained", int'(rxValid), 0);
    writeOutEn(12'hFEF);
    sendPkt(0, 4, 1, 10, hs, wr);
    cmp("R4 disabled out nak", hs, 2);
    sendPkt(0, 1, 1, 5, hs, wr);
    cmp("R4 buffer kept after nak", wr, 7); cmp("R3 ack len", hs, 1);
    pushId(12); pushId(13);
    autoNakEnable = 12'h060; writeOutEn(12'hFFF);
    sendPkt(0, 5, 1, 3, hs, wr);
    cmp("R8 auto-nak ep ack", hs, 1); cmp("R8 buffer", wr, 12);
    step(); cmp("R8 bit5 cleared", int'(outEnable[5]), 0);
    sendPkt(0, 5, 1, 3, hs, wr);
    cmp("R8 following out nak", hs, 2);
    sendPkt(1, 6, 1, 10, hs, wr);
    cmp("R8 setup ack", hs, 1); cmp("R8 setup buffer", wr, 13);
    step(); cmp("R8 setup keeps bit6", int'(outEnable[6]), 1);
    pushId(20);
    sendPkt(1, 8, 1, 10, hs, wr);
    cmp("R5 setup disabled silent", hs, 0); cmp("R5 no buffer", wr, -1);
    sendPkt(0, 13, 1, 10, hs, wr);
    cmp("R4 out-of-range ep nak", hs, 2);
    repeat (3) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule